// File: doc/BRIEF.md
# Isochronous Transmit Context Start Controller

This block holds the control and pointer registers for a bank of isochronous transmit DMA contexts and decides when each context starts. Software reaches it through a small memory-mapped register bus. It never writes a control word directly. Instead it writes a mask to a set address, where every one bit sets the matching control bit, or to a clear address, where every one bit clears it. Each context also has a 32-bit command pointer that the descriptor engine uses as the start address of its program.

A context starts in one of two ways. In the first, software raises the run bit while the cycle-match enable is low, and the context goes active at once. In the second, software leaves the enable high, and the context waits until a programmed 15-bit value equals the bus cycle timer. At that point hardware lowers the enable and raises the active bit in the same update. The per-context run and active flags are driven out of the block to the DMA engines. The cycle timer is an input.

Top module: `itx_ctx_bank`

## Requirements
- R1: After reset, every control word and every command pointer reads 0, and `ctx_active` and `ctx_run` are all zero.
- R2: Context n owns byte addresses 0x200 + 0x10·n through 0x20F + 0x10·n. Within that span, offset +0x0 is the set port, +0x4 is the clear port, +0x8 is reserved and +0xC is the command pointer. A write to one context leaves every other context unchanged.
- R3: A write to the set port sets each software-writable control bit whose mask bit is 1 and leaves all other bits unchanged.
- R4: A write to the clear port clears each software-writable control bit whose mask bit is 1 and leaves all other bits unchanged.
- R5: A read of either the set or the clear address returns the same control word. Its layout is bits [14:0] the match value, bit 16 the cycle-match enable, bit 17 active and bit 18 run. All other bits read 0.
- R6: The reserved offset reads 0 and ignores writes. Addresses outside 0x200–0x27F also read 0 and ignore writes.
- R7: The command pointer is a plain 32-bit read/write register.
- R8: If run becomes 1 while the cycle-match enable is 0, active becomes 1 on the same clock edge that run does.
- R9: While run and the enable are both 1, active stays 0 until `cycle_timer[26:12]` (the low two seconds bits followed by the 13-bit cycle count) equals the match value. On the edge after the match is seen, the enable reads 0 and active reads 1.
- R10: If run and the enable are both 1 and software clears the enable before a match, the context becomes active on the edge of that write.
- R11: Clearing run drives active to 0 on the same edge that run falls.
- R12: Software cannot set or clear the active bit (bit 17). When a match fires in the same cycle that software sets the enable, the hardware clear wins and the enable reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data or mask |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational by default |
| cycle_timer | input | 32 | Bus cycle timer (seconds [31:25], count [24:12], offset [11:0]) |
| ctx_active | output | 8 | Per-context active flag |
| ctx_run | output | 8 | Per-context run flag |

## Verification
A wrong enable or active bit in one context shows up in two places: on that context's `ctx_active` pin on the very next edge, and in bit 16 or 17 of its control word on the next read of either port. A decode fault sends state to the wrong context or into the reserved slot, so it is exposed by reading back the neighbouring contexts and the reserved offset right after each write. The compare is checked in both directions: the timer is held off the match value while the context waits, and then moved onto it for a single cycle.

// File: rtl/itx_pkg.sv
package itx_pkg;
   // register slot within a context's 16-byte stride (offset bits [3:2])
   typedef enum logic [1:0] {
      SLOT_SET = 2'd0,
      SLOT_CLR = 2'd1,
      SLOT_RSV = 2'd2,
      SLOT_PTR = 2'd3
   } itx_slot_e;

   localparam int MATCH_W  = 15;
   localparam int MEN_BIT  = 16;
   localparam int ACT_BIT  = 17;
   localparam int RUN_BIT  = 18;
   localparam int STRIDE_B = 16;
   localparam int TMR_LSB  = 12;
endpackage

// File: rtl/itx_addr_decode.sv
module itx_addr_decode
   import itx_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int BASE   = 'h200,
   parameter int N_CTX  = 8,
   localparam int IDX_W = $clog2(N_CTX)
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [IDX_W-1:0]  idx,
   output itx_slot_e         slot
);
   localparam int LIMIT = BASE + N_CTX * STRIDE_B;

   logic [31:0] a32;
   logic [31:0] off;

   always_comb begin
      a32  = 32'(addr);
      off  = a32 - 32'(BASE);
      hit  = (a32 >= 32'(BASE)) && (a32 < 32'(LIMIT));
      idx  = off[IDX_W+3:4];
      slot = itx_slot_e'(off[3:2]);
   end
endmodule

// File: rtl/itx_ctx_ctrl.sv
module itx_ctx_ctrl
   import itx_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_stb,
   input  logic              clr_stb,
   input  logic              ptr_stb,
   input  logic [DATA_W-1:0] wdata,
   input  logic [MATCH_W-1:0] cmp_now,
   output logic [DATA_W-1:0] ctl_word,
   output logic [DATA_W-1:0] ptr_word,
   output logic              run,
   output logic              active
);
   localparam logic [DATA_W-1:0] MATCH_MASK = DATA_W'((1 << MATCH_W) - 1);

   logic               run_q, act_q, men_q;
   logic [MATCH_W-1:0] match_q;
   logic [DATA_W-1:0]  ptr_q;

   logic [DATA_W-1:0]  set_m, clr_m;
   logic               run_n, men_sw, men_n, act_n, hit, fire;
   logic [MATCH_W-1:0] match_n;

   always_comb begin
      set_m   = set_stb ? wdata : '0;
      clr_m   = clr_stb ? wdata : '0;
      run_n   = (run_q | set_m[RUN_BIT]) & ~clr_m[RUN_BIT];
      men_sw  = (men_q | set_m[MEN_BIT]) & ~clr_m[MEN_BIT];
      match_n = (match_q | set_m[MATCH_W-1:0]) & ~clr_m[MATCH_W-1:0];
      hit     = (match_q == cmp_now);
      fire    = run_q & men_q & hit;
      // hardware clear of the enable overrides any software set this cycle
      men_n   = fire ? 1'b0 : men_sw;
      act_n   = run_n & (act_q | fire | ~men_n);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         act_q   <= 1'b0;
         men_q   <= 1'b0;
         match_q <= '0;
         ptr_q   <= '0;
      end else begin
         run_q   <= run_n;
         act_q   <= act_n;
         men_q   <= men_n;
         match_q <= match_n;
         if (ptr_stb) ptr_q <= wdata;
      end
   end

   always_comb begin
      ctl_word                 = '0;
      ctl_word[MATCH_W-1:0]    = match_q;
      ctl_word[MEN_BIT]        = men_q;
      ctl_word[ACT_BIT]        = act_q;
      ctl_word[RUN_BIT]        = run_q;
   end

   assign ptr_word = ptr_q;
   assign run      = run_q;
   assign active   = act_q;

   // R9: a match while running clears the enable and starts the context
   p_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && men_q && (match_q == cmp_now) && !(clr_stb && wdata[RUN_BIT]))
      |=> (active && !men_q));

   // R8: running with the enable low always means active
   p_start_now_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !men_q) |-> act_q);

   // R10 / R9: active only rises with the enable low or after a match
   p_rise_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act_q) |-> (!men_q || $past(run_q && men_q && (match_q == cmp_now))));

   // R11: run falling takes active down with it
   p_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_q) |-> !act_q);

   // R12: software can never raise active while run is low
   p_act_ro_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && set_stb && wdata[ACT_BIT] && !wdata[RUN_BIT]) |=> !act_q);

   // R7: pointer holds when not written
   p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ptr_stb |=> $stable(ptr_q));

   initial begin
      assert (MATCH_MASK != '0) else $error("match field empty");
   end
endmodule

// File: rtl/itx_ctx_bank.sv
module itx_ctx_bank
   import itx_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int DATA_W  = 32,
   parameter int N_CTX   = 8,
   parameter int BASE    = 'h200,
   parameter int TMR_W   = 32,
   parameter bit RD_PIPE = 1'b0,
   localparam int IDX_W  = $clog2(N_CTX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [TMR_W-1:0]  cycle_timer,
   output logic [N_CTX-1:0]  ctx_active,
   output logic [N_CTX-1:0]  ctx_run
);
   // elaboration-time parameter checks
   if (N_CTX < 2)                       begin : g_bad_n   $error("N_CTX must be at least 2"); end
   if (DATA_W < RUN_BIT + 1)            begin : g_bad_dw  $error("DATA_W too narrow for control word"); end
   if (TMR_W < TMR_LSB + MATCH_W)       begin : g_bad_tw  $error("TMR_W too narrow for cycle compare"); end
   if (BASE + N_CTX * STRIDE_B > (1 << ADDR_W)) begin : g_bad_aw $error("register window exceeds ADDR_W"); end
   if (BASE % STRIDE_B != 0)            begin : g_bad_base $error("BASE must be stride aligned"); end

   logic             dec_hit;
   logic [IDX_W-1:0] dec_idx;
   itx_slot_e        dec_slot;

   itx_addr_decode #(
      .ADDR_W (ADDR_W),
      .BASE   (BASE),
      .N_CTX  (N_CTX)
   ) u_dec (
      .addr (bus_addr),
      .hit  (dec_hit),
      .idx  (dec_idx),
      .slot (dec_slot)
   );

   logic [MATCH_W-1:0] cmp_now;
   assign cmp_now = cycle_timer[TMR_LSB +: MATCH_W];

   logic [DATA_W-1:0] ctl_arr [N_CTX];
   logic [DATA_W-1:0] ptr_arr [N_CTX];

   for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
      logic sel;
      assign sel = bus_wr && dec_hit && (dec_idx == IDX_W'(c));

      itx_ctx_ctrl #(.DATA_W(DATA_W)) u_ctx (
         .clk      (clk),
         .rst_n    (rst_n),
         .set_stb  (sel && dec_slot == SLOT_SET),
         .clr_stb  (sel && dec_slot == SLOT_CLR),
         .ptr_stb  (sel && dec_slot == SLOT_PTR),
         .wdata    (bus_wdata),
         .cmp_now  (cmp_now),
         .ctl_word (ctl_arr[c]),
         .ptr_word (ptr_arr[c]),
         .run      (ctx_run[c]),
         .active   (ctx_active[c])
      );
   end

   logic [DATA_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      if (dec_hit) begin
         unique case (dec_slot)
            SLOT_SET, SLOT_CLR: rd_mux = ctl_arr[dec_idx];
            SLOT_PTR:           rd_mux = ptr_arr[dec_idx];
            default:            rd_mux = '0;
         endcase
      end
   end

   if (RD_PIPE) begin : g_rd_reg
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_q <= '0;
         else        rd_q <= rd_mux;
      end
      assign bus_rdata = rd_q;
   end else begin : g_rd_comb
      assign bus_rdata = rd_mux;

      // R6: reserved slot and addresses outside the window read zero
      p_rsv_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (!dec_hit || dec_slot == SLOT_RSV) |-> (bus_rdata == '0));
   end

   // R11: no context is active without run
   p_act_needs_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ctx_active & ~ctx_run) == '0);

   // R2: one bus write reaches at most one context's run flag
   p_one_ctx_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ctx_run ^ $past(ctx_run)) <= 1);
endmodule

// File: tb/itx_ctx_bank_bench.sv
module itx_ctx_bank_bench;
   localparam int BASE = 'h200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] cycle_timer = '0;
   logic [7:0]  ctx_active, ctx_run;

   always #10 clk = ~clk;   // 50 MHz

   itx_ctx_bank u_itx_ctx_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_addr    (bus_addr),
      .bus_wr      (bus_wr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .cycle_timer (cycle_timer),
      .ctx_active  (ctx_active),
      .ctx_run     (ctx_run)
   );

   typedef struct {
      int          kind;   // 0 read data, 1 active vector, 2 run vector
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t queue_q[$];
   event  ev_chk;
   int    n_vec = 0;
   int    n_bad = 0;
   bit    done  = 1'b0;

   // monitor: pops expected items and compares with the ports
   initial begin
      forever begin
         @(ev_chk);
         while (queue_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = queue_q.pop_front();
            case (it.kind)
               0:       act = bus_rdata;
               1:       act = {24'd0, ctx_active};
               default: act = {24'd0, ctx_run};
            endcase
            n_vec++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
         end
      end
   end

   function automatic logic [11:0] ra(int ctx, int off);
      return 12'(BASE + 16 * ctx + off);
   endfunction

   task automatic push(int kind, logic [31:0] exp, string tag);
      item_t it;
      it.kind = kind; it.exp = exp; it.tag = tag;
      queue_q.push_back(it);
      #1 ->ev_chk;
      #1;
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(logic [11:0] a, logic [31:0] exp, string tag);
      @(negedge clk);
      bus_addr = a;
      #2;
      push(0, exp, tag);
   endtask

   task automatic vec_chk(int kind, logic [7:0] exp, string tag);
      @(negedge clk);
      #2;
      push(kind, {24'd0, exp}, tag);
   endtask

   // watchdog
   initial begin
      for (int i = 0; i < 200000; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      rd_chk(ra(0, 0), 32'h0, "R1 ctx0 control");
      rd_chk(ra(7, 4), 32'h0, "R1 ctx7 control");
      rd_chk(ra(3, 12), 32'h0, "R1 ctx3 pointer");
      vec_chk(1, 8'h00, "R1 active vector");
      vec_chk(2, 8'h00, "R1 run vector");

      // R7 pointer read/write, R2 isolation
      wr(ra(3, 12), 32'hDEADBEEF);
      rd_chk(ra(3, 12), 32'hDEADBEEF, "R7 ctx3 pointer readback");
      rd_chk(ra(4, 12), 32'h0, "R2 ctx4 pointer untouched");
      wr(ra(3, 12), 32'h0000_1230);
      rd_chk(ra(3, 12), 32'h0000_1230, "R7 ctx3 pointer rewrite");

      // R3 set, R5 same value at both ports
      wr(ra(2, 0), 32'h0001_1234);
      rd_chk(ra(2, 0), 32'h0001_1234, "R3 ctx2 after set");
      rd_chk(ra(2, 4), 32'h0001_1234, "R5 ctx2 via clear address");
      rd_chk(ra(1, 0), 32'h0, "R2 ctx1 untouched");

      // R4 clear
      wr(ra(2, 4), 32'h0000_0030);
      rd_chk(ra(2, 0), 32'h0001_1204, "R4 ctx2 after clear");

      // R6 reserved and out-of-range
      wr(ra(2, 8), 32'hFFFF_FFFF);
      rd_chk(ra(2, 8), 32'h0, "R6 reserved reads zero");
      rd_chk(ra(2, 0), 32'h0001_1204, "R6 reserved write ignored");
      wr(12'h280, 32'hFFFF_FFFF);
      rd_chk(12'h280, 32'h0, "R6 out of range reads zero");
      rd_chk(ra(7, 0), 32'h0, "R6 out of range write ignored");

      // R9 wait for match
      cycle_timer = 32'h0;
      wr(ra(2, 0), 32'h0004_0000);
      rd_chk(ra(2, 0), 32'h0005_1204, "R9 waiting, not active");
      vec_chk(1, 8'h00, "R9 active low while waiting");
      @(negedge clk) cycle_timer = 32'h0120_4000;   // [26:12] = 0x1204
      @(negedge clk) cycle_timer = 32'h0;
      rd_chk(ra(2, 0), 32'h0006_1204, "R9 enable cleared, active set");
      vec_chk(1, 8'h04, "R9 active after match");

      // R8 immediate start
      wr(ra(5, 0), 32'h0004_0000);
      vec_chk(1, 8'h24, "R8 immediate active");
      vec_chk(2, 8'h24, "R8 run vector");

      // R10 clearing the enable starts the context
      wr(ra(6, 0), 32'h0001_0005);
      wr(ra(6, 0), 32'h0004_0000);
      vec_chk(1, 8'h24, "R10 ctx6 waiting");
      wr(ra(6, 4), 32'h0001_0000);
      rd_chk(ra(6, 0), 32'h0006_0005, "R10 ctx6 control");
      vec_chk(1, 8'h64, "R10 ctx6 active");

      // R11 clearing run
      wr(ra(5, 4), 32'h0004_0000);
      vec_chk(1, 8'h44, "R11 ctx5 inactive");
      rd_chk(ra(5, 0), 32'h0, "R11 ctx5 control");

      // R12 active bit read-only
      wr(ra(0, 0), 32'h0002_0000);
      rd_chk(ra(0, 0), 32'h0, "R12 set of active ignored");
      wr(ra(2, 4), 32'h0002_0000);
      rd_chk(ra(2, 0), 32'h0006_1204, "R12 clear of active ignored");

      // R12 hardware wins over software set of the enable
      wr(ra(1, 0), 32'h0005_0007);
      vec_chk(1, 8'h44, "R12 ctx1 waiting");
      @(negedge clk);
      cycle_timer = 32'h0000_7000;
      bus_addr = ra(1, 0); bus_wdata = 32'h0001_0000; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; cycle_timer = 32'h0;
      rd_chk(ra(1, 0), 32'h0006_0007, "R12 hardware clear wins");
      vec_chk(1, 8'h46, "R12 final active vector");

      done = 1'b1;
      #5;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule